// File: doc/BRIEF.md
# Tridiagonal Systolic Matrix-Vector Multiplier

This block forms y = A·x for an N×N matrix whose only nonzero entries lie on the main diagonal and on the diagonals directly above and below it. It uses three multiply-accumulate cells in a row, one for each diagonal of the band. Vector samples move through the row from the first cell to the last. Partial sums move the other way, from the last cell to the first. Each partial sum starts at zero. It gains one product in every cell where it meets a vector sample, and it is complete when it leaves the first cell.

A job begins with a one-cycle start pulse. That pulse also marks the cycle in which the operands of row 1 are on the input ports. The remaining rows follow, one every second cycle. Each row supplies its vector element and its three band coefficients. The bubble cycle between rows keeps the two opposing streams aligned, so each partial sum meets exactly the vector samples its row needs. Each coefficient is delayed so that it reaches its cell in the cycle the matching pair is there. Results come out in row order on a stream qualified by a valid flag.

Top module: `band_mv_systolic`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, resValid is 0.
- R2: A start sampled high while the block is idle defines cycle 0 of a job. The operands of row i (1-based) must be on the ports in cycle 2(i−1). Those operands are: inX = x_i, inSub = a(i,i−1), inDiag = a(i,i), inSup = a(i,i+1).
- R3: The result for row i is y_i = a(i,i−1)·x_{i−1} + a(i,i)·x_i + a(i,i+1)·x_{i+1}. All operands are 16-bit two's-complement signed values. Terms that fall outside rows or columns 1..N are zero.
- R4: resValid is high in cycle 2i+2 for each i in 1..N, and resY then carries y_i. resValid is never high in two consecutive cycles, and never high when no result is due.
- R5: The inSub value given with row 1 and the inSup value given with row N have no effect on any result.
- R6: Operand inputs have no effect in the odd cycles 1..2N−1 of a job, or while the block is idle.
- R7: A start in cycles 1..2N of a job is ignored. A start in cycle 2N+1 or later begins a new job, and the previous job's results still arrive unchanged.
- R8: Accumulation is modulo 2^32. A sum that overflows the 32-bit signed range wraps and does not saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a job; row 1 operands are on the ports in the same cycle |
| inX | input | DATA_W | Vector element x_i of the current row |
| inSub | input | DATA_W | Coefficient left of the diagonal, a(i,i−1) |
| inDiag | input | DATA_W | Diagonal coefficient a(i,i) |
| inSup | input | DATA_W | Coefficient right of the diagonal, a(i,i+1) |
| resValid | output | 1 | High for one cycle when resY holds a result |
| resY | output | ACC_W | Result y_i, signed, delivered in row order |

## Verification
A fault in the internal state shows up at the ports within a few cycles, as a wrong value or a wrong slot on the result stream. The coefficient delay lines and the vector and partial-sum registers are the sensitive points. A wrong delay, a dropped valid bit, or a reversed stream direction pairs a partial sum with the wrong vector sample or the wrong coefficient. That corrupts y_i by the time it leaves the first cell, three cycles after its row entered. A pacing fault in the control moves results off the even cycles 2i+2, or adds or drops a result. Both are visible in the same job. A restart fault mixes one job's vector samples into the last result of the previous job.

// File: rtl/bmv_pkg.sv
package bmv_pkg;

  // Number of cells: one per diagonal of a tridiagonal band.
  localparam int BAND = 3;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;   // capture one row of operands this cycle
  } bmv_ctrl_t;

endpackage

// File: rtl/bmv_cell.sv
module bmv_cell #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] xFeed,
  input  logic                     xFeedV,
  input  logic signed [ACC_W-1:0]  yFeed,
  input  logic                     yFeedV,
  input  logic signed [DATA_W-1:0] coefCur,
  output logic signed [DATA_W-1:0] xCur,
  output logic                     xCurV,
  output logic signed [ACC_W-1:0]  ySum,
  output logic                     ySumV
);

  localparam int PROD_W = 2 * DATA_W;

  logic signed [DATA_W-1:0] xR;
  logic                     xV;
  logic signed [ACC_W-1:0]  yR;
  logic                     yV;
  logic signed [PROD_W-1:0] prod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xR <= '0;
      xV <= 1'b0;
      yR <= '0;
      yV <= 1'b0;
    end else begin
      xR <= xFeed;
      xV <= xFeedV;
      yR <= yFeed;
      yV <= yFeedV;
    end
  end

  always_comb begin
    prod = coefCur * xR;
    if (xV && yV) begin
      ySum = yR + ACC_W'(prod);
    end else begin
      ySum = yR;
    end
  end

  assign ySumV = yV;
  assign xCur  = xR;
  assign xCurV = xV;

endmodule

// File: rtl/bmv_coef_feed.sv
module bmv_coef_feed #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     load,
  input  logic signed [DATA_W-1:0] coefIn,
  output logic signed [DATA_W-1:0] coefOut
);

  logic signed [DATA_W-1:0] stage [0:DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage[0] <= '0;
    end else if (load) begin
      stage[0] <= coefIn;
    end
  end

  for (genvar j = 1; j <= DEPTH; j++) begin : g_delay
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage[j] <= '0;
      end else begin
        stage[j] <= stage[j-1];
      end
    end
  end

  assign coefOut = stage[DEPTH];

endmodule

// File: rtl/bmv_ctrl.sv
module bmv_ctrl
  import bmv_pkg::*;
#(
  parameter int N = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output bmv_ctrl_t ctrl
);

  localparam int TICK_W   = $clog2(2 * N + 1);
  localparam int LAST_ROW = 2 * N - 2;
  localparam int LAST_BSY = 2 * N;

  logic              busy;
  logic [TICK_W-1:0] tick;
  logic              accept;
  logic              rowSlot;

  assign accept  = !busy && start;
  assign rowSlot = busy && !tick[0] && (tick <= TICK_W'(LAST_ROW));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      tick <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      tick <= TICK_W'(1);
    end else if (busy) begin
      if (tick == TICK_W'(LAST_BSY)) begin
        busy <= 1'b0;
        tick <= '0;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl      = '0;
    ctrl.load = accept || rowSlot;
  end

endmodule

// File: rtl/bmv_datapath.sv
module bmv_datapath
  import bmv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bmv_ctrl_t                ctrl,
  input  logic signed [DATA_W-1:0] inX,
  input  logic signed [DATA_W-1:0] inSub,
  input  logic signed [DATA_W-1:0] inDiag,
  input  logic signed [DATA_W-1:0] inSup,
  output logic                     resValid,
  output logic signed [ACC_W-1:0]  resY
);

  localparam int LAST = BAND - 1;

  // Cell k serves coefficient a(i, i+1-k): cell 0 right of diagonal,
  // cell 1 the diagonal, cell 2 left of diagonal.
  logic signed [DATA_W-1:0] coefIn  [BAND];
  logic signed [DATA_W-1:0] coefCur [BAND];
  logic signed [DATA_W-1:0] xCur    [BAND];
  logic                     xCurV   [BAND];
  logic signed [ACC_W-1:0]  ySum    [BAND];
  logic                     ySumV   [BAND];

  assign coefIn[0] = inSup;
  assign coefIn[1] = inDiag;
  assign coefIn[2] = inSub;

  for (genvar k = 0; k < BAND; k++) begin : g_cell
    logic signed [DATA_W-1:0] xFeed;
    logic                     xFeedV;
    logic signed [ACC_W-1:0]  yFeed;
    logic                     yFeedV;

    if (k == 0) begin : g_xhead
      assign xFeed  = inX;
      assign xFeedV = ctrl.load;
    end else begin : g_xlink
      assign xFeed  = xCur[k-1];
      assign xFeedV = xCurV[k-1];
    end

    if (k == LAST) begin : g_yhead
      assign yFeed  = '0;
      assign yFeedV = ctrl.load;
    end else begin : g_ylink
      assign yFeed  = ySum[k+1];
      assign yFeedV = ySumV[k+1];
    end

    bmv_coef_feed #(
      .DATA_W (DATA_W),
      .DEPTH  (LAST - k)
    ) u_feed (
      .clk     (clk),
      .rstN    (rstN),
      .load    (ctrl.load),
      .coefIn  (coefIn[k]),
      .coefOut (coefCur[k])
    );

    bmv_cell #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W)
    ) u_cell (
      .clk     (clk),
      .rstN    (rstN),
      .xFeed   (xFeed),
      .xFeedV  (xFeedV),
      .yFeed   (yFeed),
      .yFeedV  (yFeedV),
      .coefCur (coefCur[k]),
      .xCur    (xCur[k]),
      .xCurV   (xCurV[k]),
      .ySum    (ySum[k]),
      .ySumV   (ySumV[k])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resY     <= '0;
    end else begin
      resValid <= ySumV[0];
      resY     <= ySum[0];
    end
  end

endmodule

// File: rtl/band_mv_systolic.sv
module band_mv_systolic
  import bmv_pkg::*;
#(
  parameter int N      = 4,
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic signed [DATA_W-1:0] inX,
  input  logic signed [DATA_W-1:0] inSub,
  input  logic signed [DATA_W-1:0] inDiag,
  input  logic signed [DATA_W-1:0] inSup,
  output logic                     resValid,
  output logic signed [ACC_W-1:0]  resY
);

  bmv_ctrl_t ctrl;

  bmv_ctrl #(
    .N (N)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl)
  );

  bmv_datapath #(
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .inX      (inX),
    .inSub    (inSub),
    .inDiag   (inDiag),
    .inSup    (inSup),
    .resValid (resValid),
    .resY     (resY)
  );

endmodule

// File: rtl/bmv_chk.sv
module bmv_chk #(
  parameter int N = 4
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic resValid
);

  localparam int WIN_W = $clog2(2 * N + 1);
  localparam int PEN_W = $clog2(2 * N + 2) + 1;

  logic [WIN_W-1:0] win;
  logic [PEN_W-1:0] pending;
  logic             acc;

  assign acc = (win == '0) && start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      win <= '0;
    end else if (acc) begin
      win <= WIN_W'(1);
    end else if (win != '0) begin
      win <= (win == WIN_W'(2 * N)) ? '0 : win + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
    end else begin
      pending <= pending + (acc ? PEN_W'(N) : '0) - (resValid ? PEN_W'(1) : '0);
    end
  end

  // R1: output stays quiet in the first cycle after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !resValid);

  // R2: first result of an accepted job lands in cycle 4, not earlier
  a_r2_first_result: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> ##1 !resValid ##1 !resValid ##1 resValid);

  // R4: results are separated by at least one idle cycle
  a_r4_result_spacing: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R7: no result appears that an accepted job did not owe
  a_r7_no_extra_result: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (pending != '0));

endmodule

bind band_mv_systolic bmv_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .resValid (resValid)
);

// File: tb/band_mv_systolic_tb.sv
module band_mv_systolic_tb;

  localparam int N  = 4;
  localparam int DW = 16;
  localparam int AW = 32;
  localparam int QD = 512;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 start = 1'b0;
  logic signed [DW-1:0] inX = '0;
  logic signed [DW-1:0] inSub = '0;
  logic signed [DW-1:0] inDiag = '0;
  logic signed [DW-1:0] inSup = '0;
  logic                 resValid;
  logic signed [AW-1:0] resY;

  always #10 clk = ~clk;

  band_mv_systolic #(.N(N), .DATA_W(DW), .ACC_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .inX(inX), .inSub(inSub), .inDiag(inDiag), .inSup(inSup),
    .resValid(resValid), .resY(resY)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit monOn = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  int          expCyc [QD];
  int          expRow [QD];
  logic [AW-1:0] expVal [QD];
  int head = 0;
  int tail = 0;

  logic signed [DW-1:0] jx [1:N];
  logic signed [DW-1:0] jl [1:N];
  logic signed [DW-1:0] jd [1:N];
  logic signed [DW-1:0] ju [1:N];

  int unsigned seed = 32'h1234_5678;

  function automatic logic [DW-1:0] junk();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:15];
  endfunction

  // R3, R5, R8: sum of up to three signed products, wrapped to 32 bits;
  // row 1 left coefficient and row N right coefficient never used
  function automatic logic [AW-1:0] rowExp(int i);
    longint acc;
    acc = longint'(jd[i]) * longint'(jx[i]);
    if (i > 1) acc += longint'(jl[i]) * longint'(jx[i-1]);
    if (i < N) acc += longint'(ju[i]) * longint'(jx[i+1]);
    return acc[AW-1:0];
  endfunction

  // Monitor: R2/R3/R4 slot and value, R4/R7 no stray result
  always @(negedge clk) begin
    if (monOn) begin
      if (head < tail && expCyc[head] == cyc) begin
        checks++;
        if (!resValid || resY !== expVal[head]) begin
          fails++;
          $display("FAIL R2/R3/R4 row %0d cycle %0d: got valid=%0b y=%0d, expected valid=1 y=%0d",
                   expRow[head], cyc, resValid, resY, $signed(expVal[head]));
        end
        head++;
      end else if (resValid) begin
        checks++;
        fails++;
        $display("FAIL R4/R7 stray result cycle %0d: got valid=1 y=%0d, expected valid=0",
                 cyc, resY);
      end
    end
  end

  task automatic driveGap(bit junkData);
    inX    = junkData ? junk() : '0;
    inSub  = junkData ? junk() : '0;
    inDiag = junkData ? junk() : '0;
    inSup  = junkData ? junk() : '0;
  endtask

  // R2 row pacing; R6 junk in gap cycles; R7 start pokes while busy
  task automatic launch(bit junkGap, bit pokeBusy);
    int s;
    @(negedge clk);
    s = cyc;
    for (int i = 1; i <= N; i++) begin
      expCyc[tail] = s + 2 * i + 2;
      expRow[tail] = i;
      expVal[tail] = rowExp(i);
      tail++;
    end
    for (int k = 0; k <= 2 * N; k++) begin
      if (k > 0) @(negedge clk);
      if (k % 2 == 0 && k <= 2 * N - 2) begin
        inX    = jx[k/2+1];
        inSub  = jl[k/2+1];
        inDiag = jd[k/2+1];
        inSup  = ju[k/2+1];
      end else begin
        driveGap(junkGap);
      end
      start = (k == 0) || (pokeBusy && k > 0);
    end
  endtask

  task automatic idle(int n, bit junkData);
    repeat (n) begin
      @(negedge clk);
      start = 1'b0;
      driveGap(junkData);
    end
  endtask

  task automatic fillConst(int x0, int l, int d, int u);
    for (int i = 1; i <= N; i++) begin
      jx[i] = DW'(x0 + i);
      jl[i] = DW'(l);
      jd[i] = DW'(d);
      ju[i] = DW'(u);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (resValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 during reset: got valid=%0b, expected valid=0", resValid);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (resValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset: got valid=%0b, expected valid=0", resValid);
    end
    monOn = 1'b1;
    idle(3, 1'b1);

    // R3: pure diagonal, edge coefficients zero
    fillConst(0, 0, 1, 0);
    launch(1'b0, 1'b0);
    idle(2 * N + 4, 1'b0);

    // R3, R5: all-ones band, edge coefficients present but unused
    fillConst(10, 1, 1, 1);
    launch(1'b0, 1'b0);
    idle(2 * N + 4, 1'b1);

    // R3: signed mix
    fillConst(-3, -2, 5, -7);
    jx[2] = -DW'(100);
    launch(1'b1, 1'b0);
    idle(5, 1'b1);

    // R5: large junk in row-1 left and row-N right coefficient
    fillConst(4, 3, -2, 6);
    jl[1] = DW'(16'sh7abc);
    ju[N] = DW'(-16'sd30000);
    launch(1'b1, 1'b0);
    idle(2 * N + 4, 1'b1);

    // Sweep of small signed values; back-to-back jobs (R7 earliest restart),
    // junk gaps (R6) and start pokes while busy (R7) alternate
    for (int s = 0; s < 24; s++) begin
      for (int i = 1; i <= N; i++) begin
        jx[i] = DW'((s * 7 + i * 3) % 11 - 5);
        jl[i] = DW'((s + i) % 5 - 2);
        jd[i] = DW'((s * 3 + i) % 9 - 4);
        ju[i] = DW'((s * 5 + 2 * i) % 7 - 3);
      end
      launch(s[0], s[1]);
    end
    idle(2 * N + 4, 1'b1);

    // Wide-magnitude values
    for (int s = 0; s < 8; s++) begin
      for (int i = 1; i <= N; i++) begin
        jx[i] = DW'(s * 4099 + i * 12345);
        jl[i] = DW'(s * 7919 - i * 3001);
        jd[i] = DW'(i * 9973 - s * 2027);
        ju[i] = DW'(s * 1237 + i * 20011);
      end
      launch(1'b1, s[0]);
    end
    idle(2 * N + 4, 1'b0);

    // R8: wrap on overflow, extremes
    fillConst(0, -32768, -32768, -32768);
    for (int i = 1; i <= N; i++) jx[i] = DW'(-32768);
    launch(1'b0, 1'b0);
    fillConst(0, 32767, 32767, 32767);
    for (int i = 1; i <= N; i++) jx[i] = DW'(-32768);
    launch(1'b1, 1'b1);
    idle(2 * N + 6, 1'b1);

    // R4: every expected result was delivered
    checks++;
    if (head != tail) begin
      fails++;
      $display("FAIL R4 missing results: got delivered=%0d, expected delivered=%0d", head, tail);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule